// File: doc/BRIEF.md
# Trigger Router with Programmable Delay

The trigger router connects a small set of trigger sources to a set of trigger destinations inside one board of a multi-board rig. The sources are a single-cycle trigger from the network command path and four external header pins. The destinations are a baseband buffer start, an AGC start and four header pins. A header output of one board is normally wired to a header input of the next board, so that a chain of boards can start together.

Each destination has its own source mask. A destination fires when any source in its mask fires. Each header source has a debounce stage that can be switched on or off. Switching it on adds a fixed four cycles of latency and rejects short glitches. Each destination has a shift-register delay line of 31 stages, tapped by a 5-bit setting. An early board in a chain can therefore wait for boards further down before it starts. Every accepted rising edge makes one internal event. A destination drives that event as a pulse of programmable width. All settings come through a simple write port.

Top module: `trig_router`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all outputs are low on the next cycle. All masks are cleared, debounce is off for every pin, every delay is 0 and the pulse width is 4 cycles.
- R2: Output k fires only when a source selected in its mask fires. An unselected source has no effect on it. Mask bit 0 is the network trigger, and bits 1 to 4 are header inputs 0 to 3. Output index 0 is the baseband start, 1 is the AGC start, and 2 to 5 are header outputs 0 to 3.
- R3: A network trigger sampled high at edge N makes a selected output with delay D rise right after edge N+1+D.
- R4: With debounce off, a header pin first sampled high at edge N makes a selected output with delay D rise right after edge N+3+D.
- R5: With debounce on, the same header path rises right after edge N+7+D, which is four cycles later than R4.
- R6: With debounce on, a header pin sampled high on fewer than 4 consecutive edges makes no event. A pin sampled high on 4 edges does make one.
- R7: Each output pulse lasts exactly the programmed width in cycles, from 1 to 15. A width write of 0 is stored as 1.
- R8: Each output has an independent delay of 0 to 31 cycles. A delay of 0 adds no latency.
- R9: A delay write above 31 is stored as 31.
- R10: Register map. Writes with cfg_we high take effect at that clock edge. Address 0+k holds the mask of output k in data[4:0]. Address 8+k holds the delay of output k. Address 16 holds the debounce enables, with data[3:0] covering header inputs 0 to 3. Address 17 holds the pulse width in data[3:0]. A write to any other address changes nothing.
- R11: A source held high for several cycles makes only one event. Its selected outputs give one pulse of the programmed width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| net_trig | input | 1 | Trigger from the network command path |
| hdr_in | input | 4 | External header trigger pins (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| bb_start | output | 1 | Baseband buffer start trigger |
| agc_start | output | 1 | AGC start trigger |
| hdr_out | output | 4 | Header output triggers |

## Verification
Every trial starts a trigger just before a known edge and counts edges at the following falling edges. An output's first high sample is due one sample after its latency: 1+D edges for the network source, 3+D for a plain header pin and 7+D with debounce. The pulse must then stay high for exactly the programmed width. The bench computes each due cycle and each pulse length from its own copy of the written settings, with clamping and the zero-width rule applied. Each trial lasts 70 cycles, longer than the worst case of 7+31 cycles of latency plus 15 cycles of pulse, so results never overlap. Unselected outputs and rejected glitches are checked as zero high samples over that whole window.

// File: rtl/trig_pkg.sv
// Package: shared constants of the trigger router.
// Holds the register map bases and the fixed source and destination indices.
// Assumes the address bus is wide enough for the highest base plus the output count.
package trig_pkg;
    localparam int A_MASK_BASE = 0;
    localparam int A_DLY_BASE  = 8;
    localparam int A_DBNC      = 16;
    localparam int A_WIDTH     = 17;

    localparam int SRC_NET     = 0;
    localparam int SRC_HDR0    = 1;

    localparam int DST_BB      = 0;
    localparam int DST_AGC     = 1;
    localparam int DST_HDR0    = 2;
endpackage

// File: rtl/trig_in_cond.sv
// Module: trig_in_cond
// Conditions one trigger source. When SYNC_EN is set, it synchronises the pin
// through two flops and can debounce it: a high level is accepted only after
// HOLD consecutive high samples. It then turns each accepted rising level into
// a one-cycle event. Assumes a SYNC_EN=0 source is already synchronous to clk.
module trig_in_cond #(
    parameter bit SYNC_EN = 1'b1,
    parameter int HOLD    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic dbnc_en,
    output logic ev
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic lvl;
    logic prev;

    generate
        if (SYNC_EN) begin : g_sync
            logic s1, s2, db;
            logic [CW-1:0] cnt;

            // Two-flop synchroniser for the asynchronous pin.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= pin;
                    s2 <= s1;
                end
            end

            // Debounce: count consecutive high samples and accept on the HOLD-th one.
            always_ff @(posedge clk) begin
                if (!rst_n || !s2) begin
                    cnt <= '0;
                    db  <= 1'b0;
                end else begin
                    if (cnt != CW'(HOLD - 1)) cnt <= cnt + 1'b1;
                    db <= db | (cnt == CW'(HOLD - 1));
                end
            end

            // Pick the debounced or the plain synchronised level.
            always_comb lvl = dbnc_en ? db : s2;
        end else begin : g_direct
            logic unused_dbnc;
            always_comb unused_dbnc = dbnc_en;
            // Already synchronous source: used as is.
            always_comb lvl = pin;
        end
    endgenerate

    // Rising-edge detector: one event cycle per accepted rising level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            ev   <= 1'b0;
        end else begin
            prev <= lvl;
            ev   <= lvl & ~prev;
        end
    end
endmodule

// File: rtl/trig_cfg_regs.sv
// Module: trig_cfg_regs
// Holds the configuration registers: per-destination source masks, per-destination
// delays (clamped to DLY_STAGES), per-header debounce enables and the pulse width
// (0 is stored as 1). A write lands at the edge where we is high.
// Assumes DATA_W is at least NUM_IN, DLY_W, NUM_HDR and WID_W.
module trig_cfg_regs #(
    parameter int NUM_HDR    = 4,
    parameter int NUM_IN     = 5,
    parameter int NUM_OUT    = 6,
    parameter int DLY_STAGES = 31,
    parameter int DLY_W      = 5,
    parameter int WID_W      = 4,
    parameter int WID_RST    = 4,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NUM_OUT-1:0][NUM_IN-1:0]     mask,
    output logic [NUM_OUT-1:0][DLY_W-1:0]      dly,
    output logic [NUM_HDR-1:0]                 dbnc_en,
    output logic [WID_W-1:0]                   width
);
    import trig_pkg::*;

    logic [DLY_W-1:0] dly_wr;
    logic [WID_W-1:0] wid_wr;

    // Clamp delay writes to the number of stages.
    always_comb dly_wr = (wdata > DATA_W'(DLY_STAGES)) ? DLY_W'(DLY_STAGES) : wdata[DLY_W-1:0];

    // Width writes of zero become one.
    always_comb wid_wr = (wdata[WID_W-1:0] == '0) ? WID_W'(1) : wdata[WID_W-1:0];

    // Register file: address decode and update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '0;
            dly     <= '0;
            dbnc_en <= '0;
            width   <= WID_W'(WID_RST);
        end else if (we) begin
            for (int k = 0; k < NUM_OUT; k++) begin
                if (addr == ADDR_W'(A_MASK_BASE + k)) mask[k] <= wdata[NUM_IN-1:0];
                if (addr == ADDR_W'(A_DLY_BASE + k))  dly[k]  <= dly_wr;
            end
            if (addr == ADDR_W'(A_DBNC))  dbnc_en <= wdata[NUM_HDR-1:0];
            if (addr == ADDR_W'(A_WIDTH)) width   <= wid_wr;
        end
    end
endmodule

// File: rtl/trig_out_path.sv
// Module: trig_out_path
// One destination path: a STAGES-deep shift register tapped by dly (0 bypasses
// it), then a pulse stretcher that holds the output high for width cycles.
// A new delayed event reloads the stretcher. Assumes dly never exceeds STAGES.
module trig_out_path #(
    parameter int STAGES = 31,
    parameter int DLY_W  = 5,
    parameter int WID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [DLY_W-1:0] dly,
    input  logic [WID_W-1:0] width,
    output logic             dly_out,
    output logic             out
);
    logic [STAGES-1:0] sr;
    logic [WID_W-1:0]  cnt;

    // Delay line: one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], fire};
    end

    // Tap select: zero means no added delay.
    always_comb begin
        if (dly == '0) dly_out = fire;
        else           dly_out = sr[dly - 1'b1];
    end

    // Pulse stretcher: load width on an event, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (dly_out)     cnt <= width;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // The output is high while the stretcher is loaded.
    always_comb out = (cnt != '0);
endmodule

// File: rtl/trig_router.sv
// Module: trig_router (top)
// Routes a network trigger and NUM_HDR header pins to the baseband start, the
// AGC start and NUM_HDR header outputs. Each destination has a source mask, a
// delay line and a pulse stretcher. Assumes net_trig is synchronous to clk and
// hdr_in is asynchronous.
module trig_router #(
    parameter int NUM_HDR    = 4,
    parameter int DLY_STAGES = 31,
    parameter int WID_W      = 4,
    parameter int WID_RST    = 4,
    parameter int DB_HOLD    = 4,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               net_trig,
    input  logic [NUM_HDR-1:0] hdr_in,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic               bb_start,
    output logic               agc_start,
    output logic [NUM_HDR-1:0] hdr_out
);
    import trig_pkg::*;

    localparam int NUM_IN  = NUM_HDR + 1;
    localparam int NUM_OUT = NUM_HDR + 2;
    localparam int DLY_W   = $clog2(DLY_STAGES + 1);

    logic [NUM_IN-1:0]                 pin_vec;
    logic [NUM_IN-1:0]                 dbnc_vec;
    logic [NUM_IN-1:0]                 ev_vec;
    logic [NUM_OUT-1:0][NUM_IN-1:0]    mask_cfg;
    logic [NUM_OUT-1:0][DLY_W-1:0]     dly_cfg;
    logic [NUM_HDR-1:0]                dbnc_cfg;
    logic [WID_W-1:0]                  wid_cfg;
    logic [NUM_OUT-1:0]                fire_vec;
    logic [NUM_OUT-1:0]                dly_out;
    logic [NUM_OUT-1:0]                out_vec;

    // Source vector: bit 0 is the network trigger, the header pins follow.
    always_comb pin_vec  = {hdr_in, net_trig};
    always_comb dbnc_vec = {dbnc_cfg, 1'b0};

    trig_cfg_regs #(
        .NUM_HDR(NUM_HDR), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT),
        .DLY_STAGES(DLY_STAGES), .DLY_W(DLY_W), .WID_W(WID_W),
        .WID_RST(WID_RST), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .mask(mask_cfg), .dly(dly_cfg), .dbnc_en(dbnc_cfg), .width(wid_cfg)
    );

    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_src
            trig_in_cond #(
                .SYNC_EN(i != SRC_NET), .HOLD(DB_HOLD)
            ) i_cond (
                .clk(clk), .rst_n(rst_n), .pin(pin_vec[i]),
                .dbnc_en(dbnc_vec[i]), .ev(ev_vec[i])
            );
        end

        for (genvar k = 0; k < NUM_OUT; k++) begin : g_dst
            // A destination fires when any of its selected sources fires.
            always_comb fire_vec[k] = |(ev_vec & mask_cfg[k]);

            trig_out_path #(
                .STAGES(DLY_STAGES), .DLY_W(DLY_W), .WID_W(WID_W)
            ) i_path (
                .clk(clk), .rst_n(rst_n), .fire(fire_vec[k]), .dly(dly_cfg[k]),
                .width(wid_cfg), .dly_out(dly_out[k]), .out(out_vec[k])
            );
        end
    endgenerate

    // Map the destination vector onto the named outputs.
    always_comb begin
        bb_start  = out_vec[DST_BB];
        agc_start = out_vec[DST_AGC];
        hdr_out   = out_vec[DST_HDR0 +: NUM_HDR];
    end
endmodule

// File: rtl/trig_router_chk.sv
// Module: trig_router_chk
// Assertion checker bound into trig_router. It watches the reset state, the
// single-cycle events, the link between the delay lines and the stretchers,
// and the clamping of delay writes.
module trig_router_chk #(
    parameter int NUM_IN     = 5,
    parameter int NUM_OUT    = 6,
    parameter int DLY_STAGES = 31,
    parameter int DLY_W      = 5,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [ADDR_W-1:0]              cfg_addr,
    input logic [DATA_W-1:0]              cfg_wdata,
    input logic [NUM_IN-1:0]              ev_vec,
    input logic [NUM_OUT-1:0]             dly_out,
    input logic [NUM_OUT-1:0]             out_vec,
    input logic [NUM_OUT-1:0][DLY_W-1:0]  dly_cfg
);
    import trig_pkg::*;

    // R1: reset silences every output on the next cycle.
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (out_vec == '0));

    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_src_chk
            // R11: an accepted edge makes a single-cycle event.
            a_r11_single_event: assert property (@(posedge clk) disable iff (!rst_n)
                ev_vec[i] |=> !ev_vec[i]);
        end

        for (genvar k = 0; k < NUM_OUT; k++) begin : g_dst_chk
            // R8: an output rises only after its delay line has presented an event.
            a_r8_start_follows_delay: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(out_vec[k]) |-> $past(dly_out[k]));

            // R7: an output cannot drop in the cycle after a reload.
            a_r7_hold_until_expiry: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(out_vec[k]) |-> !$past(dly_out[k]));

            // R9: an over-range delay write is stored as the maximum.
            a_r9_clamp: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_addr == ADDR_W'(A_DLY_BASE + k) && cfg_wdata > DATA_W'(DLY_STAGES))
                |=> (dly_cfg[k] == DLY_W'(DLY_STAGES)));
        end
    endgenerate
endmodule

bind trig_router trig_router_chk #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DLY_STAGES(DLY_STAGES),
    .DLY_W(DLY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ev_vec(ev_vec), .dly_out(dly_out),
    .out_vec(out_vec), .dly_cfg(dly_cfg)
);

// File: tb/test_trig_router.sv
// Bench for trig_router: directed corner cases plus seeded random configurations.
// Expected latencies and pulse widths come from bench functions and a bench
// copy of the written settings.
module test_trig_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       net_trig = 1'b0;
    logic [3:0] hdr_in = '0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       bb_start, agc_start;
    logic [3:0] hdr_out;
    logic [5:0] outs;

    int n_run  = 0;
    int n_fail = 0;
    int m_mask [6];
    int m_dly  [6];
    int m_dbnc = 0;
    int m_wid  = 4;

    always #5 clk = ~clk;

    trig_router i_trig_router (
        .clk(clk), .rst_n(rst_n), .net_trig(net_trig), .hdr_in(hdr_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .bb_start(bb_start), .agc_start(agc_start), .hdr_out(hdr_out)
    );

    always_comb outs = {hdr_out, agc_start, bb_start};

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_mask(input int k, input int v);
        wr(0 + k, v); m_mask[k] = v & 31;
    endtask

    task automatic set_dly(input int k, input int v);
        wr(8 + k, v); m_dly[k] = (v > 31) ? 31 : v;
    endtask

    task automatic set_dbnc(input int v);
        wr(16, v); m_dbnc = v & 15;
    endtask

    task automatic set_wid(input int v);
        wr(17, v); m_wid = ((v & 15) == 0) ? 1 : (v & 15);
    endtask

    // Edges from the first high sample of the source to the output rise (R3, R4, R5).
    function automatic int exp_lat(input int src, input int o);
        int l;
        if (src == 0) l = 1;
        else l = 3 + (((m_dbnc >> (src - 1)) & 1) ? 4 : 0);
        return l + m_dly[o];
    endfunction

    // Whether output o must fire for this source and pin length (R2, R6).
    function automatic bit exp_fire(input int src, input int hold, input int o);
        if (((m_mask[o] >> src) & 1) == 0) return 1'b0;
        if (src == 0) return 1'b1;
        if (((m_dbnc >> (src - 1)) & 1) && hold < 4) return 1'b0;
        return 1'b1;
    endfunction

    // Drive one source for hold samples, then watch all outputs for 70 cycles.
    task automatic trial(input int src, input int hold, input string tag);
        int first [6];
        int cnt   [6];
        int h;
        h = (src == 0) ? 1 : hold;
        for (int o = 0; o < 6; o++) begin first[o] = 0; cnt[o] = 0; end
        @(negedge clk);
        if (src == 0) net_trig = 1'b1; else hdr_in[src - 1] = 1'b1;
        for (int k = 1; k <= 70; k++) begin
            @(negedge clk);
            if (k == h) begin net_trig = 1'b0; hdr_in = '0; end
            for (int o = 0; o < 6; o++) begin
                if (outs[o]) begin
                    if (first[o] == 0) first[o] = k;
                    cnt[o]++;
                end
            end
        end
        for (int o = 0; o < 6; o++) begin
            if (exp_fire(src, hold, o)) begin
                chk($sformatf("%s out%0d rise", tag, o), first[o], exp_lat(src, o) + 1);
                chk($sformatf("%s out%0d width", tag, o), cnt[o], m_wid);
            end else begin
                chk($sformatf("%s out%0d silent", tag, o), cnt[o], 0);
            end
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int o = 0; o < 6; o++) begin m_mask[o] = 0; m_dly[o] = 0; end

        // R1: outputs low while and after reset.
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", int'(outs), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", int'(outs), 0);
        trial(0, 1, "R1 masks cleared");

        // R2, R3: the network source reaches the baseband start only.
        set_mask(0, 1);
        trial(0, 1, "R3 net to bb");
        trial(1, 6, "R2 unselected header");

        // R4, R11: header 0 to header out 0, held for six samples.
        set_mask(2, 2);
        trial(1, 6, "R4 hdr plain R11 held");
        trial(1, 1, "R4 hdr one sample");

        // R5, R6: debounce on header 0.
        set_dbnc(1);
        trial(1, 6, "R5 hdr debounced");
        trial(1, 3, "R6 short glitch");
        trial(1, 4, "R6 four samples");

        // R8: independent delays, including the maximum.
        set_mask(1, 1);
        set_dly(0, 5);
        set_dly(1, 9);
        trial(0, 1, "R8 two delays");
        set_dly(0, 31);
        trial(0, 1, "R8 max delay");

        // R9: clamping of over-range delays.
        set_dly(1, 200);
        trial(0, 1, "R9 clamp 200");
        set_dly(1, 32);
        trial(0, 1, "R9 clamp 32");

        // R7: width limits and the zero rule.
        set_wid(0);
        trial(0, 1, "R7 width zero");
        set_wid(15);
        trial(0, 1, "R7 width max");

        // R10: writes to unmapped addresses leave everything unchanged.
        wr(6, 8'hff);
        wr(30, 8'hff);
        wr(14, 8'h00);
        trial(0, 1, "R10 unmapped write");
        trial(3, 6, "R10 unmapped mask");

        // R2 R8 random: seeded random configurations and sources.
        for (int it = 0; it < 30; it++) begin
            for (int o = 0; o < 6; o++) begin
                set_mask(o, int'($urandom_range(0, 31)));
                set_dly(o, int'($urandom_range(0, 40)));
            end
            set_dbnc(int'($urandom_range(0, 15)));
            set_wid(int'($urandom_range(0, 15)));
            trial(int'($urandom_range(0, 4)), int'($urandom_range(1, 6)),
                  $sformatf("R2 R8 random %0d", it));
        end

        finish_run();
    end
endmodule